// File: doc/BRIEF.md
# Top External Interrupt Selector with Claim

This block takes a vector of pending message identities, a matching enable vector, a priority threshold and a delivery-control word. From these it picks the highest-priority message that can be delivered. An identity is its own priority, so a smaller number means a more urgent message, and identity 0 is reserved to mean "nothing". The block drives a registered external-interrupt request toward the hart. It also presents a registered 32-bit top-interrupt word that carries the winning identity in two fields.

Software reads the top word to learn which message won. It claims that message by writing to the same word, normally as an atomic swap with zero. A claim produces a single-cycle clear strobe that carries the identity to clear. The storage that holds the pending bits uses this strobe to drop the bit. The block stores no vectors itself and decodes no addresses.

Top module: `xint_topsel`

## Requirements
- R1: Of the identities that are both pending (`pend_i[n]`=1) and enabled (`en_i[n]`=1), the lowest-numbered one is the winner.
- R2: An identity n can win only when `thresh_i` is 0 or n < `thresh_i`; an identity equal to or above a nonzero threshold is ignored.
- R3: The top word `topei_o` holds the winner's identity in bits 26:16 and the same number as its priority in bits 10:0. Every other bit is zero.
- R4: When no identity can win, `topei_o` is 0 and `irq_o` is low.
- R5: `irq_o` is high only when `deliv_i` equals exactly 1 and a winner exists. Any other delivery value, including 0x4000_0000, keeps it low while `topei_o` still shows the winner.
- R6: Identity 0 is never selected, even when pending and enabled, and it does not hide a higher-numbered winner.
- R7: `topei_o` and `irq_o` are registered. They reflect the inputs sampled at the previous rising clock edge and do not change before that edge.
- R8: While `claim_i` is high and `topei_o` is nonzero, `clr_o` is high in the same cycle and `clr_id_o` equals the identity in `topei_o` during that cycle. This holds even if a more urgent message becomes pending in that same cycle.
- R9: A claim while `topei_o` is 0 leaves `clr_o` low, so no pending bit is cleared.
- R10: While `rst_n` is low, and at the first clock edge after its release, `topei_o` is 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_i | input | NUM_IDS | Pending bit per identity |
| en_i | input | NUM_IDS | Enable bit per identity |
| thresh_i | input | 11 | Priority threshold, 0 = no threshold |
| deliv_i | input | 32 | Delivery control; 1 = deliver to hart |
| claim_i | input | 1 | Write half of an access to the top word |
| irq_o | output | 1 | External-interrupt request to the hart |
| topei_o | output | 32 | Top-interrupt word (identity and priority fields) |
| clr_o | output | 1 | Clear strobe for the pending bit |
| clr_id_o | output | 11 | Identity to clear while `clr_o` is high |

## Verification
The bench probes the threshold at its edge: an identity just below a nonzero threshold must win, while one equal to it must be ignored. A design that used `<=`, or that treated a threshold of 0 as "nothing allowed", would show a wrong or empty top word. It also checks identity 0 alongside identity 63. A selector that did not reserve 0 would report 0 and mask the real winner, and one that scanned in the wrong direction would return the highest identity.

In the claim test, a more urgent message arrives in the same cycle as the claim. A design that cleared from the live selection would wipe a message software never saw. Further checks set the delivery word to values other than 1 and claim while the top word is empty. A design that used delivery only as a nonzero flag would raise the request line, and one with an ungated claim would clear identity 0.

// File: rtl/xint_pkg.sv
// Package: shared widths and helpers for the top external interrupt selector.
// Assumes identities fit 11 bits (at most 2047 usable identities).
package xint_pkg;
    localparam int ID_W   = 11;
    localparam int TOP_W  = 32;
    localparam int DLV_W  = 32;
    localparam logic [DLV_W-1:0] DLV_ON = 32'd1;

    // Pack an identity into the top word: identity field and priority field.
    function automatic logic [TOP_W-1:0] pack_top(input logic [ID_W-1:0] id);
        pack_top = {5'b0, id, 5'b0, id};
    endfunction
endpackage

// File: rtl/xint_elig.sv
// Eligibility mask: marks each identity that is pending, enabled and under
// the threshold (threshold 0 lets all through). Identity 0 is always masked.
// Assumes NUM_IDS <= 2048.
module xint_elig
    import xint_pkg::*;
#(
    parameter int NUM_IDS = 64
) (
    input  logic [NUM_IDS-1:0] pend_i,
    input  logic [NUM_IDS-1:0] en_i,
    input  logic [ID_W-1:0]    thresh_i,
    output logic [NUM_IDS-1:0] elig_o
);
    localparam logic [NUM_IDS-1:0] ZERO_MASK = ~NUM_IDS'(1);

    logic              no_thr;
    logic [NUM_IDS-1:0] raw;

    // Threshold of zero disables the threshold gate.
    assign no_thr = (thresh_i == '0);

    for (genvar i = 0; i < NUM_IDS; i++) begin : g_bit
        // Per-identity gate: pending, enabled, and below threshold.
        assign raw[i] = pend_i[i] & en_i[i] & (no_thr | (ID_W'(i) < thresh_i));
    end

    // Identity 0 is reserved for "none" and never competes.
    assign elig_o = raw & ZERO_MASK;
endmodule

// File: rtl/xint_lowsel.sv
// Lowest-index finder, two levels: a find-first inside each group of GRP
// bits, then a find-first across the groups. Assumes GRP >= 2 and
// N <= 2048 so an index fits ID_W bits.
module xint_lowsel
    import xint_pkg::*;
#(
    parameter int N   = 64,
    parameter int GRP = 8
) (
    input  logic [N-1:0]    vec_i,
    output logic            hit_o,
    output logic [ID_W-1:0] idx_o
);
    localparam int NG   = (N + GRP - 1) / GRP;
    localparam int PADN = NG * GRP;
    localparam int OW   = $clog2(GRP);

    logic [PADN-1:0] pad;
    logic [NG-1:0]   ghit;
    logic [OW-1:0]   goff [NG];

    // Zero-extend the input to a whole number of groups.
    assign pad = PADN'(vec_i);

    for (genvar g = 0; g < NG; g++) begin : g_grp
        logic          gh;
        logic [OW-1:0] go;
        // Find the lowest set bit inside this group.
        always_comb begin
            gh = 1'b0;
            go = '0;
            for (int b = GRP - 1; b >= 0; b--) begin
                if (pad[g*GRP + b]) begin
                    gh = 1'b1;
                    go = OW'(b);
                end
            end
        end
        assign ghit[g] = gh;
        assign goff[g] = go;
    end

    // Pick the lowest group that has a hit and form the full index.
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int g = NG - 1; g >= 0; g--) begin
            if (ghit[g]) begin
                hit_o = 1'b1;
                idx_o = ID_W'(g * GRP) + ID_W'(goff[g]);
            end
        end
    end
endmodule

// File: rtl/xint_topsel.sv
// Top external interrupt selector: registers the winning identity and the
// request line, presents the packed top word, and turns a claim into a clear
// strobe for the identity shown in that same cycle.
// Assumes pending storage outside acts on clr_o/clr_id_o.
module xint_topsel
    import xint_pkg::*;
#(
    parameter int NUM_IDS = 64,
    parameter int GRP     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IDS-1:0] pend_i,
    input  logic [NUM_IDS-1:0] en_i,
    input  logic [ID_W-1:0]    thresh_i,
    input  logic [DLV_W-1:0]   deliv_i,
    input  logic               claim_i,
    output logic               irq_o,
    output logic [TOP_W-1:0]   topei_o,
    output logic               clr_o,
    output logic [ID_W-1:0]    clr_id_o
);
    logic [NUM_IDS-1:0] elig;
    logic               win_hit;
    logic [ID_W-1:0]    win_id;
    logic [ID_W-1:0]    top_id_q;
    logic               irq_q;

    xint_elig #(.NUM_IDS(NUM_IDS)) u_elig (
        .pend_i  (pend_i),
        .en_i    (en_i),
        .thresh_i(thresh_i),
        .elig_o  (elig)
    );

    xint_lowsel #(.N(NUM_IDS), .GRP(GRP)) u_sel (
        .vec_i(elig),
        .hit_o(win_hit),
        .idx_o(win_id)
    );

    // Register the winner and the delivery-gated request line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_id_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            top_id_q <= win_hit ? win_id : '0;
            irq_q    <= win_hit && (deliv_i == DLV_ON);
        end
    end

    // Present the packed top word and the request line.
    assign topei_o = pack_top(top_id_q);
    assign irq_o   = irq_q;

    // A claim clears the identity visible now, and only if one is shown.
    assign clr_o    = claim_i && (top_id_q != '0);
    assign clr_id_o = top_id_q;
endmodule

// File: rtl/xint_topsel_chk.sv
// Checker for xint_topsel: relates the registered outputs to the inputs of
// the previous cycle, and the clear strobe to the claim input.
module xint_topsel_chk
    import xint_pkg::*;
#(
    parameter int NUM_IDS = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_IDS-1:0] pend_i,
    input logic [NUM_IDS-1:0] en_i,
    input logic [ID_W-1:0]    thresh_i,
    input logic [DLV_W-1:0]   deliv_i,
    input logic               claim_i,
    input logic               irq_o,
    input logic [TOP_W-1:0]   topei_o,
    input logic               clr_o,
    input logic [ID_W-1:0]    clr_id_o
);
    logic [NUM_IDS-1:0] pe_d;
    logic [ID_W-1:0]    top_id;

    // Remember last cycle's pending-and-enabled vector.
    always_ff @(posedge clk) pe_d <= pend_i & en_i;

    assign top_id = topei_o[26:16];

    // R1: a shown identity was pending and enabled one cycle earlier.
    assert_win_enabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (top_id != '0) |-> (((pe_d >> top_id) & NUM_IDS'(1)) != '0));

    // R2: a shown identity lies below a nonzero threshold of last cycle.
    assert_below_thresh_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((top_id != '0) && ($past(thresh_i) != '0)) |-> (top_id < $past(thresh_i)));

    // R5: the request line needs delivery equal to 1 last cycle.
    assert_irq_deliv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(deliv_i) == DLV_ON));

    // R4: a raised request always comes with a nonzero top word.
    assert_irq_has_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (topei_o != '0));

    // R9: a claim on an empty top word produces no clear.
    assert_no_clear_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_i && (topei_o == '0)) |-> !clr_o);

    // R6: a clear never targets the reserved identity.
    assert_clear_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |-> (clr_id_o != '0));
endmodule

bind xint_topsel xint_topsel_chk #(.NUM_IDS(NUM_IDS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend_i  (pend_i),
    .en_i    (en_i),
    .thresh_i(thresh_i),
    .deliv_i (deliv_i),
    .claim_i (claim_i),
    .irq_o   (irq_o),
    .topei_o (topei_o),
    .clr_o   (clr_o),
    .clr_id_o(clr_id_o)
);

// File: tb/tb_xint_topsel.sv
// Bench for xint_topsel: a vector table walked by one loop, then directed
// tests for reset, latency and claim corner cases.
module tb_xint_topsel;
    localparam int N = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pend_i = '0;
    logic [N-1:0]  en_i = '0;
    logic [10:0]   thresh_i = '0;
    logic [31:0]   deliv_i = '0;
    logic          claim_i = 1'b0;
    logic          irq_o;
    logic [31:0]   topei_o;
    logic          clr_o;
    logic [10:0]   clr_id_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    xint_topsel #(.NUM_IDS(N)) dut (
        .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .en_i(en_i),
        .thresh_i(thresh_i), .deliv_i(deliv_i), .claim_i(claim_i),
        .irq_o(irq_o), .topei_o(topei_o), .clr_o(clr_o), .clr_id_o(clr_id_o)
    );

    typedef struct packed {
        logic [63:0] p;
        logic [63:0] e;
        logic [10:0] t;
        logic [31:0] d;
        logic [10:0] id;
        logic        irq;
        logic [3:0]  req;
    } vec_t;

    localparam logic [63:0] ALL = '1;
    localparam vec_t VECS [13] = '{
        '{64'h0,            ALL,          11'd0,  32'd1,          11'd0,  1'b0, 4'd4}, // R4
        '{64'h414,          ALL,          11'd0,  32'd1,          11'd2,  1'b1, 4'd1}, // R1
        '{64'h414,          64'h410,      11'd0,  32'd1,          11'd4,  1'b1, 4'd1}, // R1
        '{64'h414,          ALL,          11'd3,  32'd1,          11'd2,  1'b1, 4'd2}, // R2
        '{64'h414,          ALL,          11'd2,  32'd1,          11'd0,  1'b0, 4'd2}, // R2
        '{64'h100_0000_0400, ALL,         11'd40, 32'd1,          11'd10, 1'b1, 4'd2}, // R2
        '{64'h100_0000_0400, ALL,         11'd11, 32'd1,          11'd10, 1'b1, 4'd2}, // R2
        '{64'h100_0000_0400, ALL,         11'd10, 32'd1,          11'd0,  1'b0, 4'd2}, // R2
        '{64'h20,           ALL,          11'd0,  32'd0,          11'd5,  1'b0, 4'd5}, // R5
        '{64'h20,           ALL,          11'd0,  32'h4000_0000,  11'd5,  1'b0, 4'd5}, // R5
        '{64'h1,            ALL,          11'd0,  32'd1,          11'd0,  1'b0, 4'd6}, // R6
        '{64'h8000_0000_0000_0000, ALL,   11'd0,  32'd1,          11'd63, 1'b1, 4'd1}, // R1
        '{64'h8000_0000_0000_0001, ALL,   11'd0,  32'd1,          11'd63, 1'b1, 4'd6}  // R6
    };

    function automatic logic [31:0] exp_top(input logic [10:0] id);
        exp_top = {5'b0, id, 5'b0, id};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        #(8 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        // R10: reset state even with pending inputs present
        pend_i = 64'h414; en_i = ALL; deliv_i = 32'd1;
        repeat (3) @(negedge clk);
        chk("R10 top in reset", 64'(topei_o), 64'h0);
        chk("R10 irq in reset", 64'(irq_o), 64'h0);
        pend_i = '0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 top after release", 64'(topei_o), 64'h0);

        // Vector table: drive, let one edge register, sample.
        foreach (VECS[k]) begin
            pend_i = VECS[k].p; en_i = VECS[k].e;
            thresh_i = VECS[k].t; deliv_i = VECS[k].d;
            @(negedge clk);
            chk($sformatf("R%0d R3 vec%0d top", VECS[k].req, k), 64'(topei_o), 64'(exp_top(VECS[k].id)));
            chk($sformatf("R%0d vec%0d irq", VECS[k].req, k), 64'(irq_o), 64'(VECS[k].irq));
        end

        // R7: no change before the edge, update right after it.
        pend_i = '0; en_i = ALL; thresh_i = '0; deliv_i = 32'd1;
        @(negedge clk);
        pend_i = 64'h40;
        #1;
        chk("R7 before edge", 64'(topei_o), 64'h0);
        @(negedge clk);
        chk("R7 after edge", 64'(topei_o), 64'(exp_top(11'd6)));

        // R8: claim while a more urgent message arrives in the same cycle.
        pend_i = 64'h88;
        @(negedge clk);
        chk("R8 top before claim", 64'(topei_o), 64'(exp_top(11'd3)));
        chk("R8 no strobe without claim", 64'(clr_o), 64'h0);
        claim_i = 1'b1;
        pend_i = 64'h8A;
        #1;
        chk("R8 strobe", 64'(clr_o), 64'h1);
        chk("R8 cleared id", 64'(clr_id_o), 64'd3);
        @(negedge clk);
        claim_i = 1'b0;
        chk("R8 new winner shown", 64'(topei_o), 64'(exp_top(11'd1)));

        // R9: claim with an empty top word
        pend_i = '0;
        @(negedge clk);
        chk("R9 top empty", 64'(topei_o), 64'h0);
        claim_i = 1'b1;
        #1;
        chk("R9 no strobe", 64'(clr_o), 64'h0);
        @(negedge clk);
        claim_i = 1'b0;

        finish_run();
    end
endmodule